// File: doc/BRIEF.md
# Timer interrupt status and prescaler-reset control

This block sits beside an 8-bit timer/counter and holds the state software uses to service it. The state is two interrupt flags (compare match and overflow), their enable bits, and the control bits that restart the timer's prescaler. The counter logic delivers single-cycle event pulses. The block latches these pulses into flags and raises one interrupt request per source when the global enable, the source enable and the flag are all set. It clears a flag when the interrupt controller acknowledges that source, or when software writes a one to the flag.

A byte-wide register port gives access to a mask register, a flag register and a general control register. Reads are combinational. Writing one to the prescaler-reset bit drives a restart pulse to the prescaler. The bit normally drops on the next cycle. It stays set while the sync-hold bit is set, so several timers can be held and released together. In asynchronous mode it stays set until the prescaler reports that the restart is done. In PWM mode the overflow flag follows the counter's direction reversal at zero and ignores wraparound.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `irq_o` is 0 and `psr_rst_o` is 0.
- R2: Register addresses are mask = 0, flag = 1, control = 2. In the mask and flag registers, bits 7:2 always read zero and writes to them have no effect. In the control register, bits 6:1 read zero.
- R3: A compare event sets flag bit 1 and an overflow event sets flag bit 0. Each flag reads as set from the cycle after the event.
- R4: Writing one to a flag bit clears it. Writing zero to a flag bit leaves it unchanged.
- R5: An acknowledge pulse on `irq_ack_i[i]` clears flag bit i. Bit 1 is compare and bit 0 is overflow.
- R6: If an event arrives in the same cycle as a write-one clear or an acknowledge of its flag, the flag ends up set.
- R7: `irq_o[i]` is high exactly when `gie_i`, mask bit i and flag bit i are all one. The request follows its inputs in the same cycle.
- R8: With `pwm_mode_i` high, the overflow flag is set by `dir_rev_zero_i` and `ovf_evt_i` is ignored. With `pwm_mode_i` low, the reverse holds.
- R9: Writing one to control bit 0 raises `psr_rst_o` in the next cycle. With sync-hold clear and async mode off, the bit reads back as one for exactly one cycle and then clears.
- R10: While control bit 7 (sync hold) is one, the prescaler-reset bit is not cleared by hardware. It clears one cycle after sync hold is written to zero.
- R11: With `async_mode_i` high, the prescaler-reset bit stays one until `psr_done_i` is sampled high. It clears at that edge.
- R12: Address 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_evt_i | input | 1 | Compare-match event pulse |
| ovf_evt_i | input | 1 | Wraparound event pulse |
| dir_rev_zero_i | input | 1 | Direction reversal at zero (PWM) pulse |
| pwm_mode_i | input | 1 | Timer runs in PWM mode |
| async_mode_i | input | 1 | Prescaler runs asynchronously |
| psr_done_i | input | 1 | Prescaler confirms restart completed |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 2 | Interrupt acknowledge pulses (1 = compare, 0 = overflow) |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 2 | Interrupt requests (1 = compare, 0 = overflow) |
| psr_rst_o | output | 1 | Prescaler restart request |

## Verification
The hardest case to reach is the prescaler-reset bit's decision to stay set or clear. That decision depends on three independent conditions, sync hold, async mode and the done handshake, and it is taken one cycle after the write. The bench sweeps all eight combinations, writing the control register with the done input held at a fixed level, and samples the output in the cycle that decides release. A separate sequence releases sync hold by writing zero to it, so that the one extra cycle of hold is visible. The race between an event and a clear is reached by driving the event pulse in the same cycle as the write strobe or the acknowledge.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_SRC  = 2;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CMP  = 1;
  localparam int PSR_BIT  = 0;
  localparam int SYNC_BIT = DATA_W - 1;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_FLAG = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_irq_flag_cell.sv
module tmr_irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic wclr_i,
  input  logic ack_i,
  input  logic en_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // event has priority so no event is lost to a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (evt_i)            flag_q <= 1'b1;
    else if (wclr_i || ack_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i & gie_i;
endmodule

// File: rtl/tmr_psr_ctrl.sv
module tmr_psr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic sync_wdata_i,
  input  logic psr_wdata_i,
  input  logic async_mode_i,
  input  logic done_i,
  output logic sync_o,
  output logic psr_o
);
  logic sync_q, psr_q, keep;

  // hold while sync hold is set, or while an async restart is pending
  assign keep = sync_q | (async_mode_i & ~done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      psr_q  <= 1'b0;
    end else begin
      if (ctrl_we_i) sync_q <= sync_wdata_i;
      if (ctrl_we_i && psr_wdata_i) psr_q <= 1'b1;
      else                          psr_q <= psr_q & keep;
    end
  end

  assign sync_o = sync_q;
  assign psr_o  = psr_q;
endmodule

// File: rtl/tmr_irq_regif.sv
module tmr_irq_regif
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic               sync_i,
  input  logic               psr_i,
  output logic               mask_we_o,
  output logic [NUM_SRC-1:0] flag_wclr_o,
  output logic               ctrl_we_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic sel_mask, sel_flag, sel_ctrl;

  assign sel_mask = (addr_i == ADDR_W'(REG_MASK));
  assign sel_flag = (addr_i == ADDR_W'(REG_FLAG));
  assign sel_ctrl = (addr_i == ADDR_W'(REG_CTRL));

  assign mask_we_o   = we_i & sel_mask;
  assign ctrl_we_o   = we_i & sel_ctrl;
  assign flag_wclr_o = (we_i & sel_flag) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_mask) rdata_o[NUM_SRC-1:0] = en_i;
    if (sel_flag) rdata_o[NUM_SRC-1:0] = flag_i;
    if (sel_ctrl) begin
      rdata_o[SYNC_BIT] = sync_i;
      rdata_o[PSR_BIT]  = psr_i;
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_evt_i,
  input  logic              ovf_evt_i,
  input  logic              dir_rev_zero_i,
  input  logic              pwm_mode_i,
  input  logic              async_mode_i,
  input  logic              psr_done_i,
  input  logic              gie_i,
  input  logic [1:0]        irq_ack_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [1:0]        irq_o,
  output logic              psr_rst_o
);
  logic [NUM_SRC-1:0] en_q, flag_q, flag_wclr, evt;
  logic               mask_we, ctrl_we, sync_q;

  assign evt[SRC_CMP] = cmp_evt_i;
  assign evt[SRC_OVF] = pwm_mode_i ? dir_rev_zero_i : ovf_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (mask_we) en_q <= reg_wdata_i[NUM_SRC-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    tmr_irq_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[i]),
      .wclr_i (flag_wclr[i]),
      .ack_i  (irq_ack_i[i]),
      .en_i   (en_q[i]),
      .gie_i  (gie_i),
      .flag_o (flag_q[i]),
      .irq_o  (irq_o[i])
    );
  end

  tmr_irq_regif #(.ADDR_W(ADDR_W)) u_regif (
    .addr_i      (reg_addr_i),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .en_i        (en_q),
    .flag_i      (flag_q),
    .sync_i      (sync_q),
    .psr_i       (psr_rst_o),
    .mask_we_o   (mask_we),
    .flag_wclr_o (flag_wclr),
    .ctrl_we_o   (ctrl_we),
    .rdata_o     (reg_rdata_o)
  );

  tmr_psr_ctrl u_psr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .sync_wdata_i (reg_wdata_i[SYNC_BIT]),
    .psr_wdata_i  (reg_wdata_i[PSR_BIT]),
    .async_mode_i (async_mode_i),
    .done_i       (psr_done_i),
    .sync_o       (sync_q),
    .psr_o        (psr_rst_o)
  );
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmp_evt_i,
  input logic              ovf_evt_i,
  input logic              dir_rev_zero_i,
  input logic              pwm_mode_i,
  input logic              async_mode_i,
  input logic              psr_done_i,
  input logic              gie_i,
  input logic [1:0]        irq_ack_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic [1:0]        irq_o,
  input logic              psr_rst_o,
  input logic [1:0]        flag_q,
  input logic              sync_q
);
  logic psr_wr, ovf_src;
  assign psr_wr  = reg_we_i && (reg_addr_i == ADDR_W'(2)) && reg_wdata_i[0];
  assign ovf_src = pwm_mode_i ? dir_rev_zero_i : ovf_evt_i;

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i < ADDR_W'(2)) |-> (reg_rdata_o[7:2] == 6'd0));
  a_r3_cmp_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_i |=> flag_q[1]);
  a_r8_ovf_src_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_src |=> flag_q[0]);
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[1] && !cmp_evt_i) |=> !flag_q[1]);
  a_r7_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != 2'b00) |-> gie_i);
  a_r7_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~flag_q) == 2'b00);
  a_r9_psr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_wr |=> psr_rst_o);
  a_r9_psr_selfclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_rst_o && !sync_q && !async_mode_i && !psr_wr) |=> !psr_rst_o);
  a_r10_sync_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_rst_o && sync_q) |=> psr_rst_o);
  a_r11_async_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_rst_o && async_mode_i && !psr_done_i) |=> psr_rst_o);
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmp_evt_i      (cmp_evt_i),
  .ovf_evt_i      (ovf_evt_i),
  .dir_rev_zero_i (dir_rev_zero_i),
  .pwm_mode_i     (pwm_mode_i),
  .async_mode_i   (async_mode_i),
  .psr_done_i     (psr_done_i),
  .gie_i          (gie_i),
  .irq_ack_i      (irq_ack_i),
  .reg_addr_i     (reg_addr_i),
  .reg_we_i       (reg_we_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .irq_o          (irq_o),
  .psr_rst_o      (psr_rst_o),
  .flag_q         (flag_q),
  .sync_q         (sync_q)
);

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmp_evt = 0, ovf_evt = 0, dir_rev = 0, pwm = 0, async_m = 0, done = 0, gie = 0;
  logic [1:0] ack = 0, addr = 0, irq;
  logic       we = 0, psr;
  logic [7:0] wdata = 0, rdata, v;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmp_evt_i(cmp_evt), .ovf_evt_i(ovf_evt),
    .dir_rev_zero_i(dir_rev), .pwm_mode_i(pwm), .async_mode_i(async_m),
    .psr_done_i(done), .gie_i(gie), .irq_ack_i(ack), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .psr_rst_o(psr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus: drive at negedge, release at next negedge
  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                      input logic c, input logic o, input logic dr, input logic [1:0] ak);
    @(negedge clk);
    we = w; addr = a; wdata = d; cmp_evt = c; ovf_evt = o; dir_rev = dr; ack = ak;
    @(negedge clk);
    we = 0; cmp_evt = 0; ovf_evt = 0; dir_rev = 0; ack = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R12 unmapped address
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset read", v, 8'h00);
    end
    chk("R1 irq", {6'd0, irq}, 8'h00);
    chk("R1 psr", {7'd0, psr}, 8'h00);

    // R2 reserved bits
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 mask reserved", v, 8'h03);
    wr(2'd1, 8'hFC); rd(2'd1, v); chk("R2 flag reserved", v, 8'h00);
    wr(2'd2, 8'h7E); rd(2'd2, v); chk("R2 ctrl reserved", v, 8'h00);
    // R12 write to address 3 changes nothing
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R12 addr3", v, 8'h00);
    rd(2'd0, v); chk("R12 mask intact", v, 8'h03);
    rd(2'd2, v); chk("R12 ctrl intact", v, 8'h00);
    chk("R12 psr", {7'd0, psr}, 8'h00);

    // R3 R7 exhaustive over gie, mask, flags
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 4; e++)
        for (int f = 0; f < 4; f++) begin
          wr(2'd1, 8'h03);
          wr(2'd0, 8'(e));
          step(1'b0, 2'd0, 8'h00, f[1], f[0], 1'b0, 2'b00);
          gie = g[0];
          rd(2'd1, v); chk("R3 flag set", v, 8'(f));
          chk("R7 irq gating", {6'd0, irq}, g ? 8'(e & f) : 8'h00);
          gie = 0;
        end

    // R4 write-one clears, write-zero keeps
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 2'b00);
    wr(2'd1, 8'h01); rd(2'd1, v); chk("R4 clear bit0", v, 8'h02);
    wr(2'd1, 8'h00); rd(2'd1, v); chk("R4 write zero keeps", v, 8'h02);
    wr(2'd1, 8'h02); rd(2'd1, v); chk("R4 clear bit1", v, 8'h00);

    // R5 acknowledge clears
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 2'b00);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10);
    rd(2'd1, v); chk("R5 ack compare", v, 8'h01);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01);
    rd(2'd1, v); chk("R5 ack overflow", v, 8'h00);

    // R6 set wins over clear
    step(1'b1, 2'd1, 8'h03, 1'b1, 1'b1, 1'b0, 2'b00);
    rd(2'd1, v); chk("R6 event vs write clear", v, 8'h03);
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 2'b11);
    rd(2'd1, v); chk("R6 event vs ack", v, 8'h03);

    // R8 overflow source by mode
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 2; o++)
        for (int d = 0; d < 2; d++) begin
          wr(2'd1, 8'h03);
          pwm = p[0];
          step(1'b0, 2'd0, 8'h00, 1'b0, o[0], d[0], 2'b00);
          rd(2'd1, v); chk("R8 overflow source", v, p ? 8'(d) : 8'(o));
          pwm = 0;
        end

    // R9 R10 R11 sweep of hold conditions
    for (int s = 0; s < 2; s++)
      for (int am = 0; am < 2; am++)
        for (int dn = 0; dn < 2; dn++) begin
          async_m = am[0]; done = dn[0];
          wr(2'd2, {s[0], 6'd0, 1'b1});
          chk("R9 psr raised", {7'd0, psr}, 8'h01);
          @(negedge clk);
          chk((s != 0) ? "R10 sync hold" : (am != 0 ? "R11 async hold" : "R9 self clear"),
              {7'd0, psr}, (s != 0 || (am != 0 && dn == 0)) ? 8'h01 : 8'h00);
          async_m = 0; done = 0;
          wr(2'd2, 8'h00);
          @(negedge clk);
          chk("R9 cleanup", {7'd0, psr}, 8'h00);
        end

    // R10 release timing
    wr(2'd2, 8'h81);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R10 held readback", v, 8'h81);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R10 one extra cycle", v, 8'h01);
    @(negedge clk);
    rd(2'd2, v); chk("R10 released", v, 8'h00);

    // R11 release on done
    async_m = 1;
    wr(2'd2, 8'h01);
    repeat (5) @(negedge clk);
    chk("R11 waiting for done", {7'd0, psr}, 8'h01);
    done = 1;
    @(negedge clk);
    chk("R11 cleared by done", {7'd0, psr}, 8'h00);
    done = 0; async_m = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule